// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures how fast each of up to three fans is turning. It does not count tach pulses per unit of time. Instead it counts ticks of a slow count-enable strobe across one tach period, which is the time between two rising edges of the fan's tach line. The result is a period, so a larger count means a slower fan. With a 22.5 kHz strobe and one pulse per revolution, count = 1 350 000 / (RPM × divisor).

A per-fan divisor of 1, 2, 4 or 8 thins out the strobe. Each step doubles the time that 255 counts cover, so slower fans can still be measured with 8-bit resolution. At nominal speed the count is 153 for every divisor; that speed is 8800 RPM at divisor 1 and halves with each larger divisor. The count saturates at 255 when no edge arrives in time, and that value means a stalled fan.

Each published count is compared against a per-fan limit. When the count is above the limit, the fan is turning slower than allowed, and the fan's slow flag is raised for an interrupt status block. A typical limit is the count seen at 70 % of nominal speed.

Each fan channel runs a two-state machine:
- ST_ARM waits for a tach edge.
- ST_MEAS accumulates strobe counts.

It has three transitions:
- T_START (ST_ARM to ST_MEAS) is taken on a rising edge and opens a window.
- T_LAP (ST_MEAS to ST_MEAS) is taken on a rising edge. It publishes the finished window and opens the next one in the same cycle.
- T_STALL (ST_MEAS to ST_ARM) is taken when the accumulator would pass 255. It publishes 255.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset every fan count reads 255 and every slow flag reads 0.
- R2: Each tach input passes through a two-flop synchronizer before rising-edge detection. A window spans the clock cycles from one detected rising edge up to, but not including, the next. The count published for it is the number of divided strobes inside it. The published value appears one clock after the closing edge is detected.
- R3: The 2-bit divisor select of a fan encodes the divisor as follows:
  - 0 selects 1.
  - 1 selects 2.
  - 2 selects 4.
  - 3 selects 8.

  One count is taken for every divisor-th strobe, and the strobe phase restarts at each window start.
- R4: The first rising edge after reset, or after a stall, only opens a window and leaves the count unchanged.
- R5: If a window would accumulate a 256th count, the count register is set to 255, the flag is evaluated, and the channel re-arms to wait for a new edge.
- R6: The slow flag is updated together with the count. It is 1 exactly when the published count is strictly greater than the fan's limit as sampled in the publishing cycle, so a count equal to the limit gives 0.
- R7: Between publications the count and flag hold their values, so no partial count is ever visible.
- R8: The divisor select is captured when a window opens. A change during a window takes effect from the next window.
- R9: Fan channels are independent. Tach activity, divisor or limit of one fan does not affect the outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-enable strobe (22.5 kHz rate in the target system), one clock wide |
| tach_in | input | NFAN | Raw tach lines, bit f for fan f |
| div_sel | input | NFAN*DW | Divisor selects, bits [f*DW +: DW] for fan f |
| fan_limit | input | NFAN*CW | Limit counts, bits [f*CW +: CW] for fan f |
| fan_count | output | NFAN*CW | Published period counts, bits [f*CW +: CW] for fan f |
| fan_slow | output | NFAN | Slow-fan flags, bit f for fan f |

## Verification
The bench runs its own cycle-level model of each channel next to the design and compares every output on every clock. It also checks computed counts at chosen points.

The corner cases it targets are the following:
- **Opening edge after reset and after a stall.** A design that published on that edge would show a junk count.
- **Count equal to the limit.** An off-by-one compare would raise the flag.
- **Divisor change in the middle of a window.** A design that used the live select would publish a mixed-scale value.
- **Stall and recovery.** A counter that wraps instead of saturating, or never re-arms, would show a small count or freeze at 255.

Other fans keep running throughout, so any crosstalk between channels is caught.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    typedef enum logic [0:0] {
        ST_ARM  = 1'b0,
        ST_MEAS = 1'b1
    } tach_state_e;

    // Mask with the lowest n bits set (n at most 8).
    function automatic logic [7:0] low_ones(input int n);
        logic [7:0] m;
        m = '0;
        for (int i = 0; i < 8; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_raw_i,
    output logic rise_o
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], tach_raw_i};
        end
    end

    // Rising edge seen on the synchronized line.
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/tach_prescale.sv
module tach_prescale #(
    parameter int DW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          restart_i,
    input  logic [DW-1:0] div_sel_i,
    output logic          strobe_o
);
    import fan_tach_pkg::*;

    localparam int PW = (1 << DW) - 1;

    logic [DW-1:0] div_q;
    logic [DW-1:0] div_eff;
    logic [PW-1:0] pre_q;
    logic [PW-1:0] pre_eff;
    logic [PW-1:0] pre_n;
    logic [PW-1:0] mask_eff;
    logic [PW-1:0] mask_q;
    logic          hit;

    always_comb begin
        div_eff  = restart_i ? div_sel_i : div_q;
        mask_eff = PW'(low_ones(int'(div_eff)));
        mask_q   = PW'(low_ones(int'(div_q)));
        pre_eff  = restart_i ? '0 : pre_q;
        hit      = tick_i && (pre_eff == mask_eff);
        if (!tick_i) begin
            pre_n = pre_eff;
        end else if (hit) begin
            pre_n = '0;
        end else begin
            pre_n = pre_eff + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            pre_q <= '0;
        end else begin
            div_q <= div_eff;
            pre_q <= pre_n;
        end
    end

    assign strobe_o = hit;

    // R3: a divided count only ever coincides with an input strobe.
    a_r3_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> tick_i);

    // R3: the phase counter never runs past the captured divisor.
    a_r3_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= mask_q);

endmodule

// File: rtl/tach_chan.sv
module tach_chan #(
    parameter int CW          = 8,
    parameter int DW          = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          tach_i,
    input  logic [DW-1:0] div_sel_i,
    input  logic [CW-1:0] limit_i,
    output logic [CW-1:0] count_o,
    output logic          slow_o
);
    import fan_tach_pkg::*;

    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    tach_state_e   state_q, state_n;
    logic          rise;
    logic          strobe;
    logic [CW-1:0] acc_q, acc_n;
    logic          publish;
    logic [CW-1:0] pub_val;
    logic [CW-1:0] count_q;
    logic          slow_q;

    tach_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .tach_raw_i(tach_i),
        .rise_o    (rise)
    );

    tach_prescale #(.DW(DW)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .restart_i(rise),
        .div_sel_i(div_sel_i),
        .strobe_o (strobe)
    );

    // Next state and datapath control.
    always_comb begin
        state_n = state_q;
        acc_n   = acc_q;
        publish = 1'b0;
        pub_val = acc_q;
        unique case (state_q)
            ST_ARM: begin
                if (rise) begin
                    state_n = ST_MEAS;                 // T_START
                    acc_n   = {{(CW-1){1'b0}}, strobe};
                end
            end
            ST_MEAS: begin
                if (rise) begin                        // T_LAP
                    publish = 1'b1;
                    pub_val = acc_q;
                    acc_n   = {{(CW-1){1'b0}}, strobe};
                end else if (strobe) begin
                    if (acc_q == CMAX) begin           // T_STALL
                        publish = 1'b1;
                        pub_val = CMAX;
                        state_n = ST_ARM;
                        acc_n   = '0;
                    end else begin
                        acc_n = acc_q + 1'b1;
                    end
                end
            end
            default: begin
                state_n = ST_ARM;
                acc_n   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARM;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            count_q <= CMAX;
            slow_q  <= 1'b0;
        end else begin
            acc_q <= acc_n;
            if (publish) begin
                count_q <= pub_val;
                slow_q  <= (pub_val > limit_i);
            end
        end
    end

    assign count_o = count_q;
    assign slow_o  = slow_q;

    // R7: with no edge and no divided strobe the outputs cannot move.
    a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise || strobe) |=> ($stable(count_o) && $stable(slow_o)));

    // R4: an edge taken while armed leaves the published count alone.
    a_r4_arm_no_publish: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |=> $stable(count_o));

    // R5: overflowing the accumulator yields a full-scale count and re-arms.
    a_r5_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEAS && !rise && strobe && acc_q == CMAX)
            |=> (count_o == CMAX && state_q == ST_ARM));

    // R6: the flag agrees with the freshly published count and the limit then.
    a_r6_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
        publish |=> (slow_o == (count_o > $past(limit_i))));

endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor #(
    parameter int NFAN        = 3,
    parameter int CW          = 8,
    parameter int DW          = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic [NFAN-1:0]    tach_in,
    input  logic [NFAN*DW-1:0] div_sel,
    input  logic [NFAN*CW-1:0] fan_limit,
    output logic [NFAN*CW-1:0] fan_count,
    output logic [NFAN-1:0]    fan_slow
);

    for (genvar f = 0; f < NFAN; f++) begin : g_fan
        tach_chan #(
            .CW         (CW),
            .DW         (DW),
            .SYNC_STAGES(SYNC_STAGES)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick_en),
            .tach_i   (tach_in[f]),
            .div_sel_i(div_sel[f*DW +: DW]),
            .limit_i  (fan_limit[f*CW +: CW]),
            .count_o  (fan_count[f*CW +: CW]),
            .slow_o   (fan_slow[f])
        );
    end

endmodule

// File: tb/fan_tach_monitor_tb_top.sv
module fan_tach_monitor_tb_top;
    localparam int NF = 3;
    localparam int CW = 8;
    localparam int DW = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n   = 1'b0;
    logic             tick_en = 1'b0;
    logic [NF-1:0]    tach    = '0;
    logic [NF*DW-1:0] div     = '0;
    logic [NF*CW-1:0] lim     = '0;
    wire  [NF*CW-1:0] cnt;
    wire  [NF-1:0]    slow;

    fan_tach_monitor #(.NFAN(NF), .CW(CW), .DW(DW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .tach_in  (tach),
        .div_sel  (div),
        .fan_limit(lim),
        .fan_count(cnt),
        .fan_slow (slow)
    );

    int  n_run  = 0;
    int  n_fail = 0;
    int  cyc    = 0;
    int  period [NF];
    int  phase  [NF];
    bit  cmp_on = 0;
    bit  done   = 0;

    // Stimulus: strobe every 4th clock, square-wave tach lines.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        tick_en <= ((cyc % 4) == 0);
        for (int f = 0; f < NF; f++) begin
            if (period[f] > 0)
                tach[f] <= (((cyc - phase[f]) % period[f]) < (period[f] / 2));
            else
                tach[f] <= 1'b0;
        end
    end

    // Behavioural reference.
    int m_state [NF];
    int m_acc   [NF];
    int m_pre   [NF];
    int m_div   [NF];
    int m_cnt   [NF];
    bit m_slow  [NF];
    bit hist    [NF][3];

    always @(posedge clk) begin
        for (int f = 0; f < NF; f++) begin
            if (!rst_n) begin
                m_state[f] = 0; m_acc[f] = 0; m_pre[f] = 0; m_div[f] = 1;
                m_cnt[f] = 255; m_slow[f] = 0;
                hist[f][0] = 0; hist[f][1] = 0; hist[f][2] = 0;
            end else begin
                bit edge_s;
                bit st;
                edge_s = hist[f][1] && !hist[f][2];
                st = 0;
                if (edge_s) begin
                    m_div[f] = 1 << div[f*DW +: DW];
                    m_pre[f] = 0;
                end
                if (tick_en) begin
                    m_pre[f] = m_pre[f] + 1;
                    if (m_pre[f] == m_div[f]) begin
                        m_pre[f] = 0;
                        st = 1;
                    end
                end
                if (m_state[f] == 0) begin
                    if (edge_s) begin
                        m_state[f] = 1;
                        m_acc[f] = st;
                    end
                end else if (edge_s) begin
                    m_cnt[f]  = m_acc[f];
                    m_slow[f] = m_acc[f] > int'(lim[f*CW +: CW]);
                    m_acc[f]  = st;
                end else if (st) begin
                    if (m_acc[f] == 255) begin
                        m_cnt[f]  = 255;
                        m_slow[f] = 255 > int'(lim[f*CW +: CW]);
                        m_state[f] = 0;
                        m_acc[f] = 0;
                    end else begin
                        m_acc[f] = m_acc[f] + 1;
                    end
                end
                hist[f][2] = hist[f][1];
                hist[f][1] = hist[f][0];
                hist[f][0] = tach[f];
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Every-clock comparison against the reference (R7 count hold, R6 flag).
    always @(negedge clk) begin
        if (cmp_on) begin
            for (int f = 0; f < NF; f++) begin
                chk("R7 count vs model", int'(cnt[f*CW +: CW]), m_cnt[f]);
                chk("R6 flag vs model", int'(slow[f]), int'(m_slow[f]));
            end
        end
    end

    function automatic int cnt_of(input int f);
        return int'(cnt[f*CW +: CW]);
    endfunction

    initial begin
        for (int f = 0; f < NF; f++) begin
            period[f] = 0;
            phase[f]  = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1;
        for (int f = 0; f < NF; f++) begin
            chk("R1 reset count", cnt_of(f), 255);
            chk("R1 reset flag", int'(slow[f]), 0);
        end

        // Three fans at different periods, divisor 1.
        lim[0 +: 8]  = 8'd20;
        lim[8 +: 8]  = 8'd20;
        lim[16 +: 8] = 8'd64;
        period[0] = 64;  phase[0] = cyc + 1;
        period[1] = 128; phase[1] = cyc + 1;
        period[2] = 256; phase[2] = cyc + 1;
        repeat (32) @(negedge clk);
        chk("R4 first edge only arms", cnt_of(0), 255);
        repeat (2000) @(negedge clk);
        chk("R2 fan0 period count", cnt_of(0), 16);
        chk("R2 fan1 period count", cnt_of(1), 32);
        chk("R2 fan2 period count", cnt_of(2), 64);
        chk("R6 below limit flag", int'(slow[0]), 0);
        chk("R6 above limit flag", int'(slow[1]), 1);
        chk("R6 equal limit flag", int'(slow[2]), 0);

        // Divisor change in mid-window.
        while (((cyc - phase[2]) % 256) != 128) @(negedge clk);
        div[0 +: 2] = 2'd1;
        div[2 +: 2] = 2'd2;
        div[4 +: 2] = 2'd3;
        repeat (140) @(negedge clk);
        chk("R8 old divisor kept for open window", cnt_of(2), 64);
        repeat (300) @(negedge clk);
        chk("R3 divisor 8", cnt_of(2), 8);
        chk("R3 divisor 2", cnt_of(0), 8);
        chk("R3 divisor 4", cnt_of(1), 8);
        chk("R6 flag cleared after faster reading", int'(slow[1]), 0);

        // Stall fan1 and recover.
        period[1] = 0;
        repeat (6000) @(negedge clk);
        chk("R5 stall count", cnt_of(1), 255);
        chk("R5 stall flag", int'(slow[1]), 1);
        chk("R9 fan0 unaffected", cnt_of(0), 8);
        chk("R9 fan2 unaffected", cnt_of(2), 8);
        period[1] = 128; phase[1] = cyc + 1;
        repeat (600) @(negedge clk);
        chk("R4 re-arm after stall", cnt_of(1), 8);

        // Limit change takes effect at the next publication.
        lim[0 +: 8] = 8'd7;
        repeat (200) @(negedge clk);
        chk("R6 flag with lowered limit", int'(slow[0]), 1);
        chk("R9 fan1 flag untouched by fan0 limit", int'(slow[1]), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule